// File: doc/BRIEF.md
# Counter start and prescale front end

This block decides when a small up-counter starts and how fast it advances. One of several external trigger lines is picked by a select field. The picked line goes through a two-flop synchronizer and then through a glitch filter of programmable length. An edge detector with programmable polarity watches the filtered level. When the edge mode is zero, the trigger path is unused and two software command inputs start the counter instead.

Once the counter is running, a power-of-two prescaler produces single-cycle count-enable pulses. Each pulse advances the counter by one. A run either stops after one full pass through the counter range or wraps and keeps going. A synchronous clear returns the block to idle from any state.

Top module: `count_start_front`

## Requirements
- R1: While reset is asserted and after it is released, `count` is 0 and `running` and `cnt_en` are 0 until a start occurs.
- R2: While running, `cnt_en` pulses for one cycle every 2^`presc` clocks: codes 0 through 7 give 1, 2, 4, 8, 16, 32, 64 and 128. The first pulse comes 2^`presc` cycles after the start edge, and `cnt_en` is 0 whenever the block is idle.
- R3: `count` starts at 0 and increases by exactly one on the clock edge that ends each `cnt_en` cycle. It holds its value at all other times.
- R4: With `edge_mode` = 00, the block starts when `sw_single` or `sw_cont` is high while it is idle. `sw_single` selects a single run and wins when both are high. With any other `edge_mode`, both software inputs are ignored.
- R5: With `edge_mode` 01 the trigger starts the block on a rising edge, with 10 on a falling edge and with 11 on either edge. Only line `trig_in[trig_sel]` is observed, and `trig_once` = 1 makes a trigger-started run a single run.
- R6: `filt_len` = 0 bypasses the filter. Codes 1, 2 and 3 make the filtered level follow the synchronized trigger only after 2, 4 or 8 consecutive matching samples, so shorter pulses never start the block. Counting the edge that captures a new level into the first synchronizer flop as edge 0, `running` rises at edge 2+2^`filt_len`.
- R7: In a single run, the `cnt_en` pulse taken at `count` = 0xFFFF returns `count` to 0 and clears `running`. In a continuous run, `count` wraps to 0 and keeps counting.
- R8: Trigger edges and software start commands that arrive while the block is running have no effect: the count is not restarted.
- R9: `clr` high at a clock edge leaves the block idle with `count` = 0 after that edge. It takes priority over a start in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the filter sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 8 | External trigger lines |
| trig_sel | input | 3 | Index of the observed trigger line |
| edge_mode | input | 2 | 00 software start, 01 rising, 10 falling, 11 both edges |
| filt_len | input | 2 | 0 bypass, 1/2/3 need 2/4/8 matching samples |
| presc | input | 3 | Prescaler code, division by 2^presc |
| trig_once | input | 1 | Trigger-started runs stop after one pass |
| sw_single | input | 1 | Software single-run start command |
| sw_cont | input | 1 | Software continuous-run start command |
| clr | input | 1 | Synchronous stop and clear |
| cnt_en | output | 1 | Count-enable pulse from the prescaler |
| count | output | 16 | Counter value |
| running | output | 1 | Counter is active |

## Verification
The bench goes after filter pulses that fall just short of the required sample count: 1 sample against length 2, and 3 samples against length 4. A filter that is off by one would start the counter on them. It checks each prescaler code against the measured spacing of the enable pulses, so a shifted mask would show up as a doubled or halved period. It runs a full 65536-step pass in both run modes to catch a counter that stops one step early or fails to stop. It also sends triggers and commands into running counters and into unselected lines, where a design that restarts or listens to the wrong line would reset the count or start unexpectedly.

// File: rtl/count_start_front.sv
module count_start_front #(
  parameter int CNT_W  = 16,
  parameter int N_TRIG = 8,
  parameter int PRE_W  = 3,
  parameter int FLT_W  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_TRIG-1:0]         trig_in,
  input  logic [$clog2(N_TRIG)-1:0] trig_sel,
  input  logic [1:0]                edge_mode,
  input  logic [FLT_W-1:0]          filt_len,
  input  logic [PRE_W-1:0]          presc,
  input  logic                      trig_once,
  input  logic                      sw_single,
  input  logic                      sw_cont,
  input  logic                      clr,
  output logic                      cnt_en,
  output logic [CNT_W-1:0]          count,
  output logic                      running
);

  localparam int DIV_W = (1 << PRE_W) - 1;
  localparam int FC_W  = (1 << FLT_W) - 1;

  logic             s1, s2, filt_q, prev_q;
  logic [FC_W-1:0]  fcnt;
  logic [FC_W-1:0]  flen_m1;
  logic [DIV_W-1:0] pcnt, pmask;
  logic             once_q;
  logic             rise, fall, trig_evt, sw_go, start, start_once, last;

  assign flen_m1 = FC_W'((1 << filt_len) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= trig_in[trig_sel];
      s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      prev_q <= 1'b0;
      fcnt   <= '0;
    end else begin
      prev_q <= filt_q;
      if (s2 == filt_q) begin
        fcnt <= '0;
      end else if (fcnt >= flen_m1) begin
        filt_q <= s2;
        fcnt   <= '0;
      end else begin
        fcnt <= fcnt + 1'b1;
      end
    end
  end

  assign rise = filt_q & ~prev_q;
  assign fall = ~filt_q & prev_q;

  always_comb begin
    case (edge_mode)
      2'b01:   trig_evt = rise;
      2'b10:   trig_evt = fall;
      2'b11:   trig_evt = rise | fall;
      default: trig_evt = 1'b0;
    endcase
  end

  assign sw_go      = (edge_mode == 2'b00) & (sw_single | sw_cont);
  assign start      = ~running & (trig_evt | sw_go);
  assign start_once = (edge_mode == 2'b00) ? sw_single : trig_once;

  assign pmask  = DIV_W'((1 << presc) - 1);
  assign cnt_en = running & ((pcnt & pmask) == pmask);
  assign last   = (count == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      once_q  <= 1'b0;
      count   <= '0;
      pcnt    <= '0;
    end else if (clr) begin
      running <= 1'b0;
      once_q  <= 1'b0;
      count   <= '0;
      pcnt    <= '0;
    end else if (start) begin
      running <= 1'b1;
      once_q  <= start_once;
      count   <= '0;
      pcnt    <= '0;
    end else if (running) begin
      pcnt <= pcnt + 1'b1;
      if (cnt_en) begin
        count <= count + 1'b1;
        if (last && once_q) running <= 1'b0;
      end
    end
  end

endmodule

module count_start_front_chk #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic [PRE_W-1:0] presc,
  input logic             cnt_en,
  input logic [CNT_W-1:0] count,
  input logic             running
);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !cnt_en);

  p_div1_every_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (running && presc == '0) |-> cnt_en);

  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cnt_en && !clr && count != {CNT_W{1'b1}}) |=> (count == $past(count) + 1'b1));

  p_count_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !cnt_en && !clr) |=> $stable(count));

  p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (count == '0));

  p_end_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cnt_en && !clr && count == {CNT_W{1'b1}}) |=> (count == '0));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!running && count == '0));

endmodule

bind count_start_front count_start_front_chk #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .presc(presc),
  .cnt_en(cnt_en), .count(count), .running(running)
);

// File: tb/count_start_front_bench.sv
module count_start_front_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  trig_in = '0;
  logic [2:0]  trig_sel = '0;
  logic [1:0]  edge_mode = '0;
  logic [1:0]  filt_len = '0;
  logic [2:0]  presc = '0;
  logic        trig_once = 1'b0;
  logic        sw_single = 1'b0;
  logic        sw_cont = 1'b0;
  logic        clr = 1'b0;
  logic        cnt_en;
  logic [15:0] count;
  logic        running;

  int total = 0;
  int bad = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #4 clk = ~clk;

  count_start_front u_count_start_front (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .trig_sel(trig_sel),
    .edge_mode(edge_mode), .filt_len(filt_len), .presc(presc),
    .trig_once(trig_once), .sw_single(sw_single), .sw_cont(sw_cont),
    .clr(clr), .cnt_en(cnt_en), .count(count), .running(running)
  );

  // behavioural reference
  int  q_sync[$];
  int  m_filt, m_prev, m_run_len, m_active, m_once, m_ticks, m_phase;

  function automatic int m_en();
    int div = 1 << presc;
    return (m_active != 0 && (m_phase % div) == div - 1) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q_sync = '{0, 0};
      m_filt = 0; m_prev = 0; m_run_len = 0;
      m_active = 0; m_once = 0; m_ticks = 0; m_phase = 0;
    end else begin
      int lvl, edge_hit, go, en, need;
      lvl  = q_sync[1];
      need = 1 << filt_len;
      en   = m_en();
      case (edge_mode)
        2'd1: edge_hit = (m_filt == 1 && m_prev == 0);
        2'd2: edge_hit = (m_filt == 0 && m_prev == 1);
        2'd3: edge_hit = (m_filt != m_prev);
        default: edge_hit = 0;
      endcase
      go = (m_active == 0) && (edge_mode == 0 ? (sw_single || sw_cont) : edge_hit);
      m_prev = m_filt;
      if (lvl == m_filt) m_run_len = 0;
      else if (m_run_len + 1 >= need) begin m_filt = lvl; m_run_len = 0; end
      else m_run_len++;
      q_sync.pop_back();
      q_sync.push_front(int'(trig_in[trig_sel]));
      if (clr) begin
        m_active = 0; m_ticks = 0; m_phase = 0;
      end else if (go) begin
        m_active = 1; m_ticks = 0; m_phase = 0;
        m_once = (edge_mode == 0) ? int'(sw_single) : int'(trig_once);
      end else if (m_active != 0) begin
        m_phase = (m_phase + 1) % 128;
        if (en != 0) begin
          if (m_ticks == 65535) begin
            m_ticks = 0;
            if (m_once != 0) m_active = 0;
          end else m_ticks++;
        end
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_req, int'(running), m_active);
      chk(cur_req, int'(count), m_ticks);
      chk(cur_req, int'(cnt_en), m_en());
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_clr();
    clr = 1'b1; wait_n(1); clr = 1'b0;
  endtask

  task automatic pulse_trig(int len);
    trig_in[5] = 1'b1; wait_n(len); trig_in[5] = 1'b0; wait_n(16);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #1500000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    // R1 reset state
    wait_n(3);
    chk("R1", int'(count), 0);
    chk("R1", int'(running), 0);
    chk("R1", int'(cnt_en), 0);
    rst_n = 1'b1;
    wait_n(3);
    chk("R1", int'(running), 0);

    // R3 count steps from software start, divide by 1
    cur_req = "R3";
    sw_cont = 1'b1; wait_n(1); sw_cont = 1'b0;
    chk("R3", int'(running), 1);
    chk("R3", int'(count), 0);
    wait_n(10);
    chk("R3", int'(count), 10);
    // R9 clear stops
    cur_req = "R9";
    do_clr();
    chk("R9", int'(running), 0);
    chk("R9", int'(count), 0);
    // R9 clear beats start
    clr = 1'b1; sw_cont = 1'b1; wait_n(1); clr = 1'b0; sw_cont = 1'b0;
    chk("R9", int'(running), 0);

    // R2 prescaler periods
    cur_req = "R2";
    for (int p = 0; p < 8; p++) begin
      int t0, t1;
      presc = 3'(p);
      sw_cont = 1'b1; wait_n(1); sw_cont = 1'b0;
      t0 = 0;
      while (!cnt_en) begin wait_n(1); t0++; end
      chk("R2", t0 + 1, 1 << p);
      wait_n(1);
      t1 = 1;
      while (!cnt_en) begin wait_n(1); t1++; end
      chk("R2", t1, 1 << p);
      do_clr();
    end
    presc = 3'd0;

    // R4 software start ignored in trigger modes
    cur_req = "R4";
    edge_mode = 2'd1;
    sw_cont = 1'b1; sw_single = 1'b1; wait_n(3); sw_cont = 1'b0; sw_single = 1'b0;
    wait_n(4);
    chk("R4", int'(running), 0);

    // R5 rising edge on selected line
    cur_req = "R5";
    trig_sel = 3'd5;
    trig_in[3] = 1'b1; wait_n(3); trig_in[3] = 1'b0; wait_n(12);
    chk("R5", int'(running), 0);
    trig_in[5] = 1'b1; wait_n(12);
    chk("R5", int'(running), 1);
    do_clr();
    // R5 falling edge
    edge_mode = 2'd2;
    trig_in[5] = 1'b0; wait_n(12);
    chk("R5", int'(running), 1);
    do_clr();
    // R5 both edges
    edge_mode = 2'd3;
    trig_in[5] = 1'b1; wait_n(12);
    chk("R5", int'(running), 1);
    do_clr();
    trig_in[5] = 1'b0; wait_n(12);
    chk("R5", int'(running), 1);
    do_clr();

    // R6 filter lengths, rising mode
    cur_req = "R6";
    edge_mode = 2'd1;
    filt_len = 2'd0;
    trig_in[5] = 1'b1; wait_n(1); trig_in[5] = 1'b0;
    wait_n(3);
    chk("R6", int'(running), 1);
    do_clr(); wait_n(12);
    filt_len = 2'd1;
    pulse_trig(1);
    chk("R6", int'(running), 0);
    pulse_trig(2);
    chk("R6", int'(running), 1);
    do_clr(); wait_n(12);
    filt_len = 2'd2;
    pulse_trig(3);
    chk("R6", int'(running), 0);
    pulse_trig(4);
    chk("R6", int'(running), 1);
    do_clr(); wait_n(12);
    filt_len = 2'd3;
    pulse_trig(7);
    chk("R6", int'(running), 0);
    pulse_trig(8);
    chk("R6", int'(running), 1);
    do_clr(); wait_n(20);
    filt_len = 2'd0;

    // R8 trigger while running ignored
    cur_req = "R8";
    begin
      int c0;
      trig_in[5] = 1'b1; wait_n(6); trig_in[5] = 1'b0;
      wait_n(4);
      c0 = int'(count);
      trig_in[5] = 1'b1; wait_n(10); trig_in[5] = 1'b0; wait_n(10);
      chk("R8", int'(count), c0 + 20);
      do_clr();
      edge_mode = 2'd0;
      sw_cont = 1'b1; wait_n(1); sw_cont = 1'b0;
      wait_n(5);
      sw_single = 1'b1; wait_n(1); sw_single = 1'b0;
      wait_n(4);
      chk("R8", int'(count), 10);
      do_clr();
    end

    // R7 single run ends after full pass
    cur_req = "R7";
    sw_single = 1'b1; wait_n(1); sw_single = 1'b0;
    wait_n(65535);
    chk("R7", int'(count), 65535);
    chk("R7", int'(running), 1);
    wait_n(1);
    chk("R7", int'(running), 0);
    chk("R7", int'(count), 0);
    // R7 continuous run wraps
    sw_cont = 1'b1; wait_n(1); sw_cont = 1'b0;
    wait_n(65536);
    chk("R7", int'(running), 1);
    chk("R7", int'(count), 0);
    wait_n(1);
    chk("R7", int'(count), 1);
    do_clr();
    wait_n(2);
    finish_run();
  end

endmodule